// File: doc/BRIEF.md
# Block-Protection and Page-Select Command Unit

This unit sits beside the serial-bus transaction controller of a 512-byte presence-detect EEPROM. It handles only the command class whose device-select type nibble is 0110. For that class the command is carried in the three address bits and the read/write bit of the select byte, not in later bytes. The unit keeps four write-protect flags, one per 128-byte block, and a one-bit page register that picks the lower or upper 256 bytes. All status goes back to the bus master as ACK or NoAck. No data byte carries it.

The transaction controller reports bus events to the unit as single-cycle strobes. The events are: a select byte was received, a following byte was received, a stop was seen, and the internal write timer expired. The unit answers each select strobe and each following-byte strobe with a one-cycle response that carries the ACK decision. When a protect or clear-all command completes, it requests an internal write cycle. The protect flags change only when that cycle ends. A page-select command takes effect at once. The protect vector and the page bit are outputs at all times, so the array-write path can gate its writes. A separate power-on reset clears the protect flags. The ordinary reset leaves them as they are.

Top module: `spd_prot_unit`

## Requirements
- R1: A select byte whose bits [7:4] are not 0110 produces no response pulse, and changes neither flags nor page. Later byte strobes of that transaction also get no response.
- R2: With bit 0 = 0, the codes in bits [3:1] set protection as follows: 001 block 0, 100 block 1, 101 block 2, 000 block 3. The command is accepted when hv_det is high, the block is unprotected and no write cycle is pending. It then gets ACK on the select byte and on each following byte. A stop that comes after at least two following bytes, with hv_det held high throughout, pulses wcyc_start in the cycle after the stop strobe.
- R3: A set-protection command aimed at a block that is already protected gets NoAck on the select byte and on every following byte, and starts no write cycle.
- R4: Code 011 with bit 0 = 0 and hv_det high is acknowledged like R2. When its write cycle completes, all four protect flags are cleared.
- R5: A set or clear command is refused with NoAck on the select byte if hv_det is low at the select. If hv_det drops later, every following byte from then on gets NoAck and the stop starts no write cycle.
- R6: prot_map bit i is the flag of block i. A flag changes only in the cycle after a wcyc_done strobe that ends a write cycle started by an accepted set or clear command.
- R7: With bit 0 = 1, the block codes of R2 read that block's status. The select byte gets ACK when the block is unprotected and NoAck when it is protected. A following byte always gets NoAck. No state changes.
- R8: Code 110 with bit 0 = 0 sets page_hi to 0, and code 111 with bit 0 = 0 sets it to 1. Both are acknowledged and visible in the same cycle as the response. Code 110 with bit 0 = 1 answers ACK for page 0 and NoAck for page 1.
- R9: The reserved combinations are code 010 with either bit 0, code 011 with bit 0 = 1, and code 111 with bit 0 = 1. They get NoAck and change nothing.
- R10: From the wcyc_start pulse until wcyc_done, every 0110 select byte gets NoAck and changes nothing.
- R11: rst_n low sets page_hi to 0, drops any pending write cycle and clears the responses. The protect flags survive it. Only por_n low clears them.
- R12: A stop after fewer than two following bytes starts no write cycle.
- R13: resp_vld is a one-cycle pulse in the cycle after each responded select or byte strobe. resp_ack is never high without resp_vld.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears protect flags |
| rst_n | input | 1 | Soft reset, active low, clears page and sequencing |
| sel_stb | input | 1 | Select byte received |
| sel_byte | input | 8 | Received select byte, bit 0 is read/write |
| byte_stb | input | 1 | Following byte received |
| stop_stb | input | 1 | Stop condition seen |
| hv_det | input | 1 | High-voltage present on the address pin |
| wcyc_done | input | 1 | Internal write cycle finished |
| resp_vld | output | 1 | Response pulse for the previous strobe |
| resp_ack | output | 1 | 1 = ACK, 0 = NoAck |
| wcyc_start | output | 1 | Request to start an internal write cycle |
| prot_map | output | 4 | Protect flag per block |
| page_hi | output | 1 | Selected 256-byte page |

## Verification
The bench attacks the scrambled block codes. A design that decodes them as binary would protect, or report on, the wrong block. The bench sets a flag, then tries to set it again and reads back its neighbours.

It drops hv_det between the two following bytes, and it stops after a single byte. A design that latches hv_det only at the select, or that does not count bytes, would start a write cycle it should refuse.

It sends selects while a write is pending and resets mid-cycle. A design that lets a command through while busy, or that applies a write abandoned by reset, would change flags it must not touch.

It checks that a soft reset keeps the flags while the page returns to 0.

// File: rtl/spd_prot_pkg.sv
package spd_prot_pkg;
   localparam int unsigned NUM_BLK = 4;
   localparam int unsigned BLK_W   = $clog2(NUM_BLK);

   typedef enum logic [2:0] {
      OP_SETP,
      OP_CLRP,
      OP_RDST,
      OP_PG0,
      OP_PG1,
      OP_RDPG,
      OP_RSV
   } op_e;

   typedef enum logic [2:0] {
      CTX_IDLE,
      CTX_SET,
      CTX_CLR,
      CTX_PAGE,
      CTX_REJ
   } ctx_e;

   typedef struct packed {
      logic             ours;
      op_e              op;
      logic [BLK_W-1:0] blk;
   } dec_s;
endpackage

// File: rtl/spd_cmd_decode.sv
module spd_cmd_decode
   import spd_prot_pkg::*;
#(
   parameter logic [3:0] TYPE_CODE = 4'b0110
) (
   input  logic [7:0] sel_byte,
   output dec_s       dec
);
   logic [2:0] code;
   logic       rd;

   assign code = sel_byte[3:1];
   assign rd   = sel_byte[0];

   always_comb begin
      dec.ours = (sel_byte[7:4] == TYPE_CODE);
      dec.op   = OP_RSV;
      dec.blk  = '0;
      // block order is not binary: the code-to-block map is fixed
      unique case (code)
         3'b001: begin dec.blk = BLK_W'(0); dec.op = rd ? OP_RDST : OP_SETP; end
         3'b100: begin dec.blk = BLK_W'(1); dec.op = rd ? OP_RDST : OP_SETP; end
         3'b101: begin dec.blk = BLK_W'(2); dec.op = rd ? OP_RDST : OP_SETP; end
         3'b000: begin dec.blk = BLK_W'(3); dec.op = rd ? OP_RDST : OP_SETP; end
         3'b011: dec.op = rd ? OP_RSV : OP_CLRP;
         3'b110: dec.op = rd ? OP_RDPG : OP_PG0;
         3'b111: dec.op = rd ? OP_RSV : OP_PG1;
         default: dec.op = OP_RSV;
      endcase
   end
endmodule

// File: rtl/spd_prot_flags.sv
module spd_prot_flags
   import spd_prot_pkg::*;
#(
   parameter int unsigned N_BLK = NUM_BLK
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             apply,
   input  logic             apply_clr,
   input  logic [BLK_W-1:0] apply_blk,
   output logic [N_BLK-1:0] flags
);
   if (N_BLK != NUM_BLK) begin : g_bad_cnt
      $error("spd_prot_flags: block count must match the select encoding");
   end

   for (genvar gi = 0; gi < N_BLK; gi++) begin : g_flag
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)
            flags[gi] <= 1'b0;
         else if (apply && apply_clr)
            flags[gi] <= 1'b0;
         else if (apply && (apply_blk == BLK_W'(gi)))
            flags[gi] <= 1'b1;
      end
   end

   // R6
   flags_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      !$past(apply) |-> $stable(flags));

   // R4
   clr_all_chk: assert property (@(posedge clk) disable iff (!por_n)
      $past(apply && apply_clr) |-> (flags == '0));
endmodule

// File: rtl/spd_page_reg.sv
module spd_page_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic val,
   output logic page
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         page <= 1'b0;
      else if (load)
         page <= val;
   end

   // R8
   page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(load) |-> $stable(page));
endmodule

// File: rtl/spd_cmd_seq.sv
module spd_cmd_seq
   import spd_prot_pkg::*;
#(
   parameter int unsigned N_BLK     = NUM_BLK,
   parameter int unsigned MIN_BYTES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_stb,
   input  dec_s             dec,
   input  logic             byte_stb,
   input  logic             stop_stb,
   input  logic             hv_det,
   input  logic             wcyc_done,
   input  logic [N_BLK-1:0] prot_map,
   input  logic             page_hi,
   output logic             page_load,
   output logic             page_val,
   output logic             apply,
   output logic             apply_clr,
   output logic [BLK_W-1:0] apply_blk,
   output logic             resp_vld,
   output logic             resp_ack,
   output logic             wcyc_start
);
   localparam int unsigned CNT_W = $clog2(MIN_BYTES + 1);

   if (MIN_BYTES < 1) begin : g_bad_min
      $error("spd_cmd_seq: MIN_BYTES must be at least one");
   end

   ctx_e             ctx_q, sel_ctx;
   logic [BLK_W-1:0] blk_q, pblk_q;
   logic [CNT_W-1:0] cnt_q;
   logic             hv_q, busy_q, pclr_q;
   logic             sel_ack, byte_ack, cnt_full, go_write, is_wr_ctx;

   always_comb begin
      sel_ack   = 1'b0;
      sel_ctx   = CTX_REJ;
      page_load = 1'b0;
      page_val  = 1'b0;
      if (!busy_q) begin
         unique case (dec.op)
            OP_SETP: if (hv_det && !prot_map[dec.blk]) begin
                        sel_ack = 1'b1;
                        sel_ctx = CTX_SET;
                     end
            OP_CLRP: if (hv_det) begin
                        sel_ack = 1'b1;
                        sel_ctx = CTX_CLR;
                     end
            OP_RDST: sel_ack = !prot_map[dec.blk];
            OP_PG0,
            OP_PG1:  begin
                        sel_ack   = 1'b1;
                        sel_ctx   = CTX_PAGE;
                        page_load = sel_stb && dec.ours;
                        page_val  = (dec.op == OP_PG1);
                     end
            OP_RDPG: sel_ack = !page_hi;
            default: sel_ack = 1'b0;
         endcase
      end
   end

   assign is_wr_ctx = (ctx_q == CTX_SET) || (ctx_q == CTX_CLR);
   assign byte_ack  = (ctx_q == CTX_PAGE) || (is_wr_ctx && hv_q && hv_det);
   assign cnt_full  = (cnt_q == CNT_W'(MIN_BYTES));
   assign go_write  = is_wr_ctx && cnt_full && hv_q && hv_det;

   assign apply     = busy_q && wcyc_done;
   assign apply_clr = pclr_q;
   assign apply_blk = pblk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctx_q      <= CTX_IDLE;
         blk_q      <= '0;
         cnt_q      <= '0;
         hv_q       <= 1'b0;
         busy_q     <= 1'b0;
         pclr_q     <= 1'b0;
         pblk_q     <= '0;
         resp_vld   <= 1'b0;
         resp_ack   <= 1'b0;
         wcyc_start <= 1'b0;
      end else begin
         resp_vld   <= 1'b0;
         resp_ack   <= 1'b0;
         wcyc_start <= 1'b0;
         if (apply)
            busy_q <= 1'b0;
         if (sel_stb) begin
            if (dec.ours) begin
               resp_vld <= 1'b1;
               resp_ack <= sel_ack;
               ctx_q    <= sel_ctx;
               blk_q    <= dec.blk;
               cnt_q    <= '0;
               hv_q     <= hv_det;
            end else begin
               ctx_q <= CTX_IDLE;
            end
         end else if (byte_stb) begin
            if (ctx_q != CTX_IDLE) begin
               resp_vld <= 1'b1;
               resp_ack <= byte_ack;
               hv_q     <= hv_q && hv_det;
               if (!cnt_full)
                  cnt_q <= cnt_q + CNT_W'(1);
            end
         end else if (stop_stb) begin
            ctx_q <= CTX_IDLE;
            if (go_write) begin
               wcyc_start <= 1'b1;
               busy_q     <= 1'b1;
               pclr_q     <= (ctx_q == CTX_CLR);
               pblk_q     <= blk_q;
            end
         end
      end
   end

   // R13
   resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_vld |-> $past(sel_stb || byte_stb));

   // R10
   busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && sel_stb) |=> !resp_ack);

   // R2
   start_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wcyc_start |-> $past(stop_stb));

   // R5
   start_needs_hv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wcyc_start |-> $past(hv_det));
endmodule

// File: rtl/spd_prot_unit.sv
module spd_prot_unit
   import spd_prot_pkg::*;
#(
   parameter logic [3:0]  TYPE_CODE    = 4'b0110,
   parameter int unsigned MIN_WR_BYTES = 2
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               rst_n,
   input  logic               sel_stb,
   input  logic [7:0]         sel_byte,
   input  logic               byte_stb,
   input  logic               stop_stb,
   input  logic               hv_det,
   input  logic               wcyc_done,
   output logic               resp_vld,
   output logic               resp_ack,
   output logic               wcyc_start,
   output logic [NUM_BLK-1:0] prot_map,
   output logic               page_hi
);
   if (TYPE_CODE == 4'b1010) begin : g_bad_type
      $error("spd_prot_unit: type code collides with the array class");
   end

   dec_s             dec;
   logic             page_load, page_val, apply, apply_clr;
   logic [BLK_W-1:0] apply_blk;

   spd_cmd_decode #(.TYPE_CODE(TYPE_CODE)) i_dec (
      .sel_byte (sel_byte),
      .dec      (dec)
   );

   spd_cmd_seq #(.N_BLK(NUM_BLK), .MIN_BYTES(MIN_WR_BYTES)) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_stb    (sel_stb),
      .dec        (dec),
      .byte_stb   (byte_stb),
      .stop_stb   (stop_stb),
      .hv_det     (hv_det),
      .wcyc_done  (wcyc_done),
      .prot_map   (prot_map),
      .page_hi    (page_hi),
      .page_load  (page_load),
      .page_val   (page_val),
      .apply      (apply),
      .apply_clr  (apply_clr),
      .apply_blk  (apply_blk),
      .resp_vld   (resp_vld),
      .resp_ack   (resp_ack),
      .wcyc_start (wcyc_start)
   );

   spd_prot_flags #(.N_BLK(NUM_BLK)) i_flags (
      .clk       (clk),
      .por_n     (por_n),
      .apply     (apply),
      .apply_clr (apply_clr),
      .apply_blk (apply_blk),
      .flags     (prot_map)
   );

   spd_page_reg i_page (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (page_load),
      .val   (page_val),
      .page  (page_hi)
   );

   // R13
   ack_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_ack |-> resp_vld);

   // R1
   foreign_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_stb && (sel_byte[7:4] != TYPE_CODE)) |=> !resp_vld);
endmodule

// File: tb/test_spd_prot_unit.sv
`timescale 1ns/1ps
module test_spd_prot_unit;
   logic       clk = 1'b0;
   logic       por_n = 1'b0, rst_n = 1'b0;
   logic       sel_stb = 1'b0, byte_stb = 1'b0, stop_stb = 1'b0;
   logic       hv_det = 1'b0, wcyc_done = 1'b0;
   logic [7:0] sel_byte = 8'h00;
   logic       resp_vld, resp_ack, wcyc_start, page_hi;
   logic [3:0] prot_map;

   int    n_chk = 0, n_fail = 0;
   string cur_req = "R11";
   bit    armed = 1'b0;

   // reference model state
   int m_prot[4];
   int m_page = 0, m_busy = 0, m_kind = 0, m_blk = 0, m_n = 0, m_hv = 0;
   int p_clr = 0, p_blk = 0;
   int e_vld = 0, e_ack = 0, e_start = 0;

   always #2 clk = ~clk;

   spd_prot_unit i_spd_prot_unit (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .sel_stb(sel_stb),
      .sel_byte(sel_byte), .byte_stb(byte_stb), .stop_stb(stop_stb),
      .hv_det(hv_det), .wcyc_done(wcyc_done), .resp_vld(resp_vld),
      .resp_ack(resp_ack), .wcyc_start(wcyc_start), .prot_map(prot_map),
      .page_hi(page_hi)
   );

   function automatic int blk_of(input int code);
      case (code)
         1: return 0;
         4: return 1;
         5: return 2;
         0: return 3;
         default: return -1;
      endcase
   endfunction

   // kinds: 0 idle, 1 set, 2 clear, 3 page, 4 rejected
   always @(posedge clk) begin
      int was_busy, code, rd, b, h;
      if (!por_n) for (int i = 0; i < 4; i++) m_prot[i] = 0;
      if (!rst_n) begin
         m_page = 0; m_busy = 0; m_kind = 0; e_vld = 0; e_ack = 0; e_start = 0;
      end else begin
         was_busy = m_busy;
         h = int'(hv_det);
         e_vld = 0; e_ack = 0; e_start = 0;
         if (wcyc_done && was_busy) begin
            if (p_clr != 0) for (int i = 0; i < 4; i++) m_prot[i] = 0;
            else m_prot[p_blk] = 1;
            m_busy = 0;
         end
         if (sel_stb) begin
            if (sel_byte[7:4] != 4'b0110) m_kind = 0;
            else begin
               code = int'(sel_byte[3:1]); rd = int'(sel_byte[0]);
               b = blk_of(code);
               e_vld = 1; m_kind = 4; m_n = 0; m_hv = h;
               if (was_busy == 0) begin
                  if (rd == 0 && b >= 0) begin
                     if (h == 1 && m_prot[b] == 0) begin e_ack = 1; m_kind = 1; end
                     m_blk = b;
                  end else if (rd == 0 && code == 3) begin
                     if (h == 1) begin e_ack = 1; m_kind = 2; end
                  end else if (rd == 1 && b >= 0) begin
                     e_ack = (m_prot[b] == 0);
                  end else if (rd == 0 && (code == 6 || code == 7)) begin
                     e_ack = 1; m_kind = 3; m_page = (code == 7);
                  end else if (rd == 1 && code == 6) begin
                     e_ack = (m_page == 0);
                  end
               end
            end
         end else if (byte_stb) begin
            if (m_kind != 0) begin
               e_vld = 1;
               if (m_kind == 3) e_ack = 1;
               if (m_kind == 1 || m_kind == 2) begin
                  m_hv = m_hv & h;
                  e_ack = m_hv;
               end
               if (m_n < 2) m_n++;
            end
         end else if (stop_stb) begin
            if ((m_kind == 1 || m_kind == 2) && m_n >= 2 && m_hv == 1 && h == 1) begin
               e_start = 1; m_busy = 1; p_clr = (m_kind == 2); p_blk = m_blk;
            end
            m_kind = 0;
         end
      end
   end

   task automatic chk(input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (armed) begin
         int pm;
         pm = m_prot[0] + 2*m_prot[1] + 4*m_prot[2] + 8*m_prot[3];
         chk("resp_vld", int'(resp_vld), e_vld);
         chk("resp_ack", int'(resp_ack), e_ack);
         chk("wcyc_start", int'(wcyc_start), e_start);
         chk("prot_map", int'(prot_map), pm);
         chk("page_hi", int'(page_hi), m_page);
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic t_sel(input logic [7:0] b, input logic hv);
      @(negedge clk); sel_stb = 1'b1; sel_byte = b; hv_det = hv;
      @(negedge clk); sel_stb = 1'b0;
   endtask
   task automatic t_byte(input logic hv);
      @(negedge clk); byte_stb = 1'b1; hv_det = hv;
      @(negedge clk); byte_stb = 1'b0;
   endtask
   task automatic t_stop(input logic hv);
      @(negedge clk); stop_stb = 1'b1; hv_det = hv;
      @(negedge clk); stop_stb = 1'b0;
   endtask
   task automatic t_done();
      @(negedge clk); wcyc_done = 1'b1;
      @(negedge clk); wcyc_done = 1'b0;
   endtask
   task automatic t_wcmd(input logic [7:0] b);
      t_sel(b, 1'b1); t_byte(1'b1); t_byte(1'b1); t_stop(1'b1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      idle(3);
      armed = 1'b1;
      @(negedge clk); por_n = 1'b1; rst_n = 1'b1;
      cur_req = "R11"; idle(2);
      cur_req = "R1";  t_sel(8'hA8, 1'b1); t_byte(1'b1); t_byte(1'b1); t_stop(1'b1);
      t_sel(8'h34, 1'b1); idle(2);
      cur_req = "R2";  t_wcmd(8'h68); idle(3);
      cur_req = "R6";  idle(3); t_done(); idle(2);
      cur_req = "R3";  t_wcmd(8'h68); idle(2);
      cur_req = "R7";  t_sel(8'h69, 1'b0); t_byte(1'b0); t_stop(1'b0);
      t_sel(8'h63, 1'b0); t_byte(1'b0); t_stop(1'b0);
      cur_req = "R5";  t_sel(8'h62, 1'b0); t_byte(1'b0); t_byte(1'b0); t_stop(1'b0);
      t_sel(8'h6A, 1'b1); t_byte(1'b1); t_byte(1'b0); t_stop(1'b1); idle(2);
      cur_req = "R12"; t_sel(8'h60, 1'b1); t_byte(1'b1); t_stop(1'b1); idle(2);
      cur_req = "R2";  t_wcmd(8'h62);
      cur_req = "R10"; t_sel(8'h63, 1'b0); t_sel(8'h6E, 1'b0); t_wcmd(8'h6A);
      cur_req = "R6";  t_done(); idle(2);
      cur_req = "R2";  t_wcmd(8'h6A); t_done(); t_wcmd(8'h60); t_done();
      cur_req = "R7";  t_sel(8'h61, 1'b0); t_sel(8'h6B, 1'b0); t_stop(1'b0);
      cur_req = "R4";  t_wcmd(8'h66); idle(2); t_done(); idle(2);
      cur_req = "R7";  t_sel(8'h61, 1'b0); t_stop(1'b0);
      cur_req = "R8";  t_sel(8'h6D, 1'b0); t_stop(1'b0);
      t_sel(8'h6E, 1'b0); t_byte(1'b0); t_stop(1'b0);
      t_sel(8'h6D, 1'b0); t_byte(1'b0); t_stop(1'b0);
      t_sel(8'h6C, 1'b0); t_stop(1'b0); t_sel(8'h6D, 1'b0); t_stop(1'b0);
      cur_req = "R9";  t_sel(8'h64, 1'b1); t_byte(1'b1); t_byte(1'b1); t_stop(1'b1);
      t_sel(8'h65, 1'b1); t_sel(8'h67, 1'b1); t_sel(8'h6F, 1'b1); t_byte(1'b1); t_stop(1'b1);
      cur_req = "R11"; t_sel(8'h6E, 1'b0); t_wcmd(8'h68); t_done(); t_wcmd(8'h62);
      @(negedge clk); rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
      t_done(); idle(2);
      cur_req = "R13"; t_byte(1'b1); t_sel(8'h6D, 1'b0); idle(3);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule